// File: doc/BRIEF.md
# Excess-One Carry-Select Adder

This block is a purely combinational adder of two `WIDTH`-bit unsigned operands and a carry-in. It returns a `WIDTH+1`-bit result whose top bit is the carry-out. It is meant as the final carry-propagate stage behind a compression tree, or anywhere a wide add sits on a critical path.

The operand bits are split into groups. The lowest group is `$clog2(WIDTH)+1` bits wide and adds the carry-in directly. Every higher group is `$clog2(WIDTH)-1` bits wide, except the topmost group, which takes whatever bits are left over. All groups first add their own operand slices with an assumed incoming carry of zero, and they all do this at the same time.

An incrementer then forms the "carry was one" version of each upper group's word. The word is the group's sum bits with its carry on top. The carry actually arriving from the group below steers a two-input word multiplexer between the plain word and the incremented word. A resolved carry therefore crosses each group through a single multiplexer level and never ripples through that group's adder. No group holds a second adder.

Top module: `xs1_select_adder`

## Requirements
- R1: `sum_o` equals `a_i + b_i + cin_i` as a `WIDTH+1`-bit value for every input combination. Bit `WIDTH` is the carry-out. All-zero inputs give zero.
- R2: With both operands all ones and `cin_i` = 1, every one of the `WIDTH+1` output bits is 1.
- R3: Each incrementer returns its input plus one modulo 2^n. When every group word is all ones, a carry from below wraps each word to zero and passes the carry up. So `a_i` all ones, `b_i` = 0 and `cin_i` = 1 give only bit `WIDTH` set.
- R4: The low group spans operand bits `$clog2(WIDTH)` down to 0 and takes `cin_i` directly. With `a_i` = 2^L − 1 (L = `$clog2(WIDTH)+1`), `b_i` = 0 and `cin_i` = 1, the result is exactly 2^L.
- R5: Each upper group is `$clog2(WIDTH)-1` bits wide and the top group absorbs the leftover bits. The sum stays correct at widths 8, 16 and 64.
- R6: A group whose incoming carry is 0 passes its zero-carry word unchanged. So `a_i` all ones, `b_i` = 0 and `cin_i` = 0 give all ones with carry-out 0.
- R7: A group that generates a carry on its own always sends a carry upward, whatever the selection. Two operands with only the top bit set give only bit `WIDTH` set.
- R8: Each group's zero-carry adder yields exactly the sum of its two operand slices. The alternating patterns 0101… plus 1010… with `cin_i` = 1 carry through every group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | first operand |
| b_i | input | WIDTH | second operand |
| cin_i | input | 1 | carry into bit 0 |
| sum_o | output | WIDTH+1 | sum with carry-out in the top bit |

## Verification
The bench builds three copies of the block: `WIDTH` = 8, 16 and 64. The 8-bit copy has 2-bit upper groups and a 2-bit top group, so every one of its 2^17 operand and carry combinations is applied. The 16-bit copy gives three full 3-bit groups plus a 2-bit leftover group. The 64-bit copy chains twelve groups and covers the longest multiplexer path; it gets directed boundary patterns and random operands.

// File: rtl/esa_pkg.sv
package esa_pkg;

  // width of the group that adds the external carry directly
  function automatic int low_w(input int w);
    return $clog2(w) + 1;
  endfunction

  // operand bits in each selected upper group
  function automatic int seg_w(input int w);
    return $clog2(w) - 1;
  endfunction

  // number of upper groups, the last one taking the remainder
  function automatic int n_groups(input int w);
    return (w - low_w(w) + seg_w(w) - 1) / seg_w(w);
  endfunction

  function automatic int last_w(input int w);
    return w - low_w(w) - (n_groups(w) - 1) * seg_w(w);
  endfunction

endpackage

// File: rtl/xs1_incr.sv
module xs1_incr #(
  parameter int N = 4
) (
  input  logic [N-1:0] b_i,
  output logic [N-1:0] x_o
);

  // bit k flips when every lower bit is one; the all-ones word wraps to zero
  always_comb begin
    logic run;
    run = 1'b1;
    for (int k = 0; k < N; k++) begin
      x_o[k] = b_i[k] ^ run;
      run    = run & b_i[k];
    end
    a_r3_inc_plus_one: assert (x_o == b_i + N'(1))
      else $error("incrementer output is not input plus one");
  end

endmodule

// File: rtl/xs1_zadd.sv
module xs1_zadd #(
  parameter int N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         ci_i,
  output logic [N-1:0] s_o,
  output logic         co_o
);

  always_comb begin
    logic c;
    c = ci_i;
    for (int k = 0; k < N; k++) begin
      s_o[k] = a_i[k] ^ b_i[k] ^ c;
      c      = (a_i[k] & b_i[k]) | (c & (a_i[k] ^ b_i[k]));
    end
    co_o = c;
    a_r8_slice_sum: assert ({co_o, s_o} == {1'b0, a_i} + {1'b0, b_i} + (N+1)'(ci_i))
      else $error("group adder result differs from slice sum");
  end

endmodule

// File: rtl/xs1_wmux.sv
module xs1_wmux #(
  parameter int N = 4
) (
  input  logic         sel_i,
  input  logic [N-1:0] d0_i,
  input  logic [N-1:0] d1_i,
  output logic [N-1:0] y_o
);

  always_comb y_o = ({N{sel_i}} & d1_i) | ({N{~sel_i}} & d0_i);

endmodule

// File: rtl/xs1_select_adder.sv
module xs1_select_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   sum_o
);

  localparam int LOW_W = esa_pkg::low_w(WIDTH);
  localparam int SEG_W = esa_pkg::seg_w(WIDTH);
  localparam int NGRP  = esa_pkg::n_groups(WIDTH);
  localparam int LAST  = esa_pkg::last_w(WIDTH);

  wire [WIDTH:0] sum_w;
  wire [NGRP:0]  cy;   // cy[0] leaves the low group, cy[g+1] leaves upper group g

  // low group: adds the external carry itself, result goes straight out
  xs1_zadd #(.N(LOW_W)) u_low (
    .a_i  (a_i[LOW_W-1:0]),
    .b_i  (b_i[LOW_W-1:0]),
    .ci_i (cin_i),
    .s_o  (sum_w[LOW_W-1:0]),
    .co_o (cy[0])
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int GW   = (g == NGRP - 1) ? LAST : SEG_W;
    localparam int BASE = LOW_W + g * SEG_W;

    wire [GW-1:0] zs;
    wire          zc;
    wire [GW:0]   inc_w;
    wire [GW:0]   sel_w;

    // partial result assuming no carry enters this group
    xs1_zadd #(.N(GW)) u_zero (
      .a_i  (a_i[BASE +: GW]),
      .b_i  (b_i[BASE +: GW]),
      .ci_i (1'b0),
      .s_o  (zs),
      .co_o (zc)
    );

    // excess-one version of {carry, sum}
    xs1_incr #(.N(GW + 1)) u_inc (
      .b_i ({zc, zs}),
      .x_o (inc_w)
    );

    xs1_wmux #(.N(GW + 1)) u_mux (
      .sel_i (cy[g]),
      .d0_i  ({zc, zs}),
      .d1_i  (inc_w),
      .y_o   (sel_w)
    );

    assign sum_w[BASE +: GW] = sel_w[GW-1:0];
    assign cy[g+1]           = sel_w[GW];

    always_comb begin
      if (zc) begin
        a_r7_generated_carry_kept: assert (cy[g+1])
          else $error("group generated a carry that did not leave it");
      end
    end
  end

  assign sum_w[WIDTH] = cy[NGRP];
  assign sum_o        = sum_w;

  always_comb begin
    a_r1_full_sum: assert (sum_w == {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i))
      else $error("adder output differs from a + b + cin");
  end

endmodule

// File: tb/xs1_select_adder_test.sv
module xs1_select_adder_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [7:0]  a8,  b8;  logic c8;
  logic [15:0] a16, b16; logic c16;
  logic [63:0] a64, b64; logic c64;
  logic [8:0]  s8;
  logic [16:0] s16;
  logic [64:0] s64;

  xs1_select_adder #(.WIDTH(16)) uut   (.a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16));
  xs1_select_adder #(.WIDTH(8))  uut_n (.a_i(a8),  .b_i(b8),  .cin_i(c8),  .sum_o(s8));
  xs1_select_adder #(.WIDTH(64)) uut_w (.a_i(a64), .b_i(b64), .cin_i(c64), .sum_o(s64));

  logic [8:0]  q8[$];
  logic [16:0] q16[$];
  logic [64:0] q64[$];
  string       qtag[$];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic drive(input logic [7:0] x8, input logic [7:0] y8, input logic k8,
                       input logic [15:0] x16, input logic [15:0] y16, input logic k16,
                       input logic [63:0] x64, input logic [63:0] y64, input logic k64,
                       input string tag);
    @(posedge clk);
    a8  = x8;  b8  = y8;  c8  = k8;
    a16 = x16; b16 = y16; c16 = k16;
    a64 = x64; b64 = y64; c64 = k64;
    q8.push_back({1'b0, x8} + {1'b0, y8} + 9'(k8));
    q16.push_back({1'b0, x16} + {1'b0, y16} + 17'(k16));
    q64.push_back({1'b0, x64} + {1'b0, y64} + 65'(k64));
    qtag.push_back(tag);
  endtask

  // monitor: results are combinational, compare half a cycle after driving
  always @(negedge clk) begin
    if (qtag.size() > 0) begin
      logic [8:0]  e8;
      logic [16:0] e16;
      logic [64:0] e64;
      string       t;
      e8 = q8.pop_front(); e16 = q16.pop_front(); e64 = q64.pop_front();
      t  = qtag.pop_front();
      checks += 3;
      if (s8 !== e8) begin
        errors++;
        $display("FAIL %s width8 actual %h expected %h", t, s8, e8);
      end
      if (s16 !== e16) begin
        errors++;
        $display("FAIL %s width16 actual %h expected %h", t, s16, e16);
      end
      if (s64 !== e64) begin
        errors++;
        $display("FAIL %s width64 actual %h expected %h", t, s64, e64);
      end
    end
  end

  initial begin
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a64 = '0; b64 = '0; c64 = 1'b0;

    // R1: all-zero inputs
    drive('0, '0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, "R1");
    // R2: all ones plus carry-in
    drive('1, '1, 1'b1, '1, '1, 1'b1, '1, '1, 1'b1, "R2");
    // R3: carry wraps every group word to zero
    drive('1, '0, 1'b1, '1, '0, 1'b1, '1, '0, 1'b1, "R3");
    // R6: no incoming carry anywhere, direct words pass
    drive('1, '0, 1'b0, '1, '0, 1'b0, '1, '0, 1'b0, "R6");
    // R4: low group (L = clog2(W)+1 bits) all ones plus cin crosses into group 0
    drive(8'h0f, '0, 1'b1, 16'h001f, '0, 1'b1, 64'h7f, '0, 1'b1, "R4");
    // R7: top-bit carry generated inside the top group
    drive(8'h80, 8'h80, 1'b0, 16'h8000, 16'h8000, 1'b0,
          64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R7");
    // R8: alternating patterns
    drive(8'h55, 8'haa, 1'b1, 16'h5555, 16'haaaa, 1'b1,
          {16{4'h5}}, {16{4'ha}}, 1'b1, "R8");
    drive(8'haa, 8'haa, 1'b0, 16'haaaa, 16'haaaa, 1'b0,
          {16{4'ha}}, {16{4'ha}}, 1'b0, "R8");

    // R5: random operands at the wider geometries
    for (int i = 0; i < 2000; i++) begin
      drive(8'($urandom), 8'($urandom), 1'($urandom),
            16'($urandom), 16'($urandom), 1'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R5");
    end

    // R1: exhaustive sweep of the 8-bit copy
    for (int i = 0; i < (1 << 17); i++) begin
      logic [16:0] v;
      v = 17'(i);
      drive(v[7:0], v[15:8], v[16],
            16'($urandom), 16'($urandom), 1'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1");
    end

    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule